// File: doc/BRIEF.md
# Infrared Carrier Mark-Space Modulator

This block drives an infrared transmit pin. A small carrier generator makes a square wave out of two programmable counts: cycles high and cycles low. A modulation timer splits time into a mark interval, when the gate is open, and a space interval, when the gate is closed. The mark and space values are programmable. The timer is one 17-bit down counter that carries a sign bit. While the counter is not negative, the gate is open. Once the counter wraps below zero, the bitwise complement of its low 16 bits is compared against the space value. When they match, the counter reloads and a one-cycle period-complete pulse is raised.

There are three ways of combining the gate and the carrier:
- **Time mode** passes the carrier only while the gate is open.
- **Baseband mode** drives the gate level straight to the pin.
- **FSK mode** always sends the carrier. After every complete modulation period it swaps between two sets of carrier counts.

The modulation timer advances either on every clock cycle or once per carrier period. When the block is disabled, the pin shows a software latch bit instead of the modulator. A polarity bit inverts the pin in every case.

Top module: `irmod_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with `cfg_en` low and `cfg_latch` and `cfg_pol` both 0, `ir_out` and `period_done` are 0.
- R2: For a mark value M and a space value S, the gate is open for M+1 timer ticks and closed for S+1 ticks. `period_done` is high for exactly one clock cycle at each reload. With the per-cycle tick, consecutive pulses are therefore M+S+2 cycles apart.
- R3: In time mode (`cfg_mode` = 0, and also the unused code 3), the pin shows the carrier while the gate is open and the idle level while the gate is closed.
- R4: In baseband mode (`cfg_mode` = 1), the pin shows the gate level and the carrier has no effect.
- R5: In FSK mode (`cfg_mode` = 2):
  - the timer ticks once per carrier period;
  - the pin always shows the carrier;
  - each reload swaps between count set 1 (`cfg_hi1`/`cfg_lo1`) and count set 2 (`cfg_hi2`/`cfg_lo2`), starting from set 1.
- R6: While the block is not running, `ir_out` follows `cfg_latch` (through polarity) with one cycle of latency. The block is not running when `cfg_en` is low, and also on the first enabled edge.
- R7: When `cfg_pol` is 1, the pin level is inverted, for both the modulator output and the latch.
- R8: A mark of 0 still gives one open tick, and a space of 0 gives one closed tick. With mark 0 and space 0 on the per-cycle tick, the pulses are 2 cycles apart.
- R9: Mark and space are captured only at enable and at each reload. A change in the middle of a period takes effect only after the next reload.
- R10: The carrier is high for the high count and then low for the low count, in clock cycles. A count of 0 acts as 1.
- R11: When `cfg_clksrc` is 0 in time or baseband mode, the timer ticks every cycle. When it is 1, the timer ticks once at the end of each carrier period.
- R12: On the first clock edge with `cfg_en` high after it was low, the block does three things:
  - the timer loads the mark value;
  - count set 1 is selected;
  - the carrier restarts at the start of its high phase.

  The carrier also restarts high at each FSK swap. `ir_out` reflects the modulator state one cycle after each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Run the modulator |
| cfg_mode | input | 2 | 0 time, 1 baseband, 2 FSK |
| cfg_clksrc | input | 1 | Timer tick: 0 every cycle, 1 per carrier period |
| cfg_pol | input | 1 | Invert the output pin |
| cfg_latch | input | 1 | Pin level while disabled |
| cfg_mark | input | 16 | Mark period value |
| cfg_space | input | 16 | Space period value |
| cfg_hi1 | input | 8 | Carrier set 1 high count |
| cfg_lo1 | input | 8 | Carrier set 1 low count |
| cfg_hi2 | input | 8 | Carrier set 2 high count |
| cfg_lo2 | input | 8 | Carrier set 2 low count |
| ir_out | output | 1 | Infrared transmit output, registered |
| period_done | output | 1 | One-cycle pulse at each modulation reload |

## Verification
The bench measures the gaps between `period_done` pulses in several cases:
- Zero mark and space values. A timer that skips the open tick or the closed tick would give a gap of 1 or 0 cycles instead of 2.
- Values changed in the middle of a period. A design that reads the live values would cut the period short.
- The carrier-period tick, which a timer counting clock cycles would run too fast.
- FSK, where the gaps must alternate between the two carrier sets.

The carrier duty and the restart in the high phase are checked on the pin. Random mode, polarity and latch changes are compared every cycle against a reference model in the bench. That model catches wrong latency, inverted polarity and a modulator that leaks through while disabled.

// File: rtl/irmod_pkg.sv
package irmod_pkg;
  typedef enum logic [1:0] {
    MODE_TIME = 2'd0,
    MODE_BASE = 2'd1,
    MODE_FSK  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_t;
endpackage

// File: rtl/irmod_carrier.sv
module irmod_carrier #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          sel,
  input  logic [CW-1:0] hi1,
  input  logic [CW-1:0] lo1,
  input  logic [CW-1:0] hi2,
  input  logic [CW-1:0] lo2,
  output logic          carrier,
  output logic          period_end
);
  logic [CW-1:0] hi_raw, lo_raw, hi_eff, lo_eff, ccnt;
  logic          ph_hi, hi_last, lo_last;

  // pick the active count set; a zero count is stretched to one cycle
  assign hi_raw  = sel ? hi2 : hi1;
  assign lo_raw  = sel ? lo2 : lo1;
  assign hi_eff  = (hi_raw == '0) ? CW'(1) : hi_raw;
  assign lo_eff  = (lo_raw == '0) ? CW'(1) : lo_raw;
  assign hi_last = (ccnt == hi_eff - CW'(1));
  assign lo_last = (ccnt == lo_eff - CW'(1));

  assign period_end = run & ~ph_hi & lo_last;
  assign carrier    = ph_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_hi <= 1'b1;
      ccnt  <= '0;
    end else if (restart) begin
      ph_hi <= 1'b1;
      ccnt  <= '0;
    end else if (run) begin
      if (ph_hi) begin
        if (hi_last) begin
          ph_hi <= 1'b0;
          ccnt  <= '0;
        end else begin
          ccnt <= ccnt + CW'(1);
        end
      end else begin
        if (lo_last) begin
          ph_hi <= 1'b1;
          ccnt  <= '0;
        end else begin
          ccnt <= ccnt + CW'(1);
        end
      end
    end
  end

  // R10: the high phase only ends once its full count has elapsed
  p_high_len_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(ph_hi) |-> $past(hi_last));

  // R12: a restart always leaves the carrier in its high phase
  p_restart_high_r12: assert property (@(posedge clk) disable iff (rst)
    restart |=> (carrier && ccnt == '0));
endmodule

// File: rtl/irmod_modtimer.sv
module irmod_modtimer #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic          tick,
  input  logic          fsk,
  input  logic [MW-1:0] mark,
  input  logic [MW-1:0] space,
  output logic          gate,
  output logic          done,
  output logic          sel,
  output logic          fsk_switch
);
  localparam int CNTW = MW + 1;

  logic [CNTW-1:0] cnt;
  logic [MW-1:0]   space_sh;
  logic            neg, wrap;

  // sign bit set means the mark interval has run out
  assign neg        = cnt[CNTW-1];
  assign gate       = ~neg;
  assign wrap       = neg & ((~cnt[MW-1:0]) == space_sh);
  assign fsk_switch = run & tick & wrap & fsk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      space_sh <= '0;
      sel      <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      cnt      <= {1'b0, mark};
      space_sh <= space;
      sel      <= 1'b0;
      done     <= 1'b0;
    end else if (run && tick) begin
      if (wrap) begin
        cnt      <= {1'b0, mark};
        space_sh <= space;
        done     <= 1'b1;
        if (fsk) sel <= ~sel;
      end else begin
        cnt  <= cnt - CNTW'(1);
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R2: a reload always reopens the gate, and pulses never touch
  p_done_opens_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> gate);
  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R12: a start always lands in the mark interval with set 1
  p_start_load_r12: assert property (@(posedge clk) disable iff (rst)
    start |=> (gate && !sel));
endmodule

// File: rtl/irmod_outstage.sv
module irmod_outstage
  import irmod_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  active,
  input  mode_t mode,
  input  logic  gate,
  input  logic  carrier,
  input  logic  latch,
  input  logic  pol,
  output logic  ir_out
);
  logic mod_out, raw;

  always_comb begin
    case (mode)
      MODE_BASE: mod_out = gate;
      MODE_FSK:  mod_out = carrier;
      default:   mod_out = gate & carrier;
    endcase
  end

  assign raw = active ? mod_out : latch;

  always_ff @(posedge clk) begin
    if (rst) ir_out <= 1'b0;
    else     ir_out <= raw ^ pol;
  end

  // R6: a block that is not running shows the latch
  p_latch_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> ir_out == ($past(latch) ^ $past(pol)));
  // R4: baseband follows the gate
  p_baseband_level_r4: assert property (@(posedge clk) disable iff (rst)
    (active && mode == MODE_BASE) |=> ir_out == ($past(gate) ^ $past(pol)));
  // R3: a closed gate in time mode gives the idle level
  p_time_closed_r3: assert property (@(posedge clk) disable iff (rst)
    (active && mode == MODE_TIME && !gate) |=> ir_out == $past(pol));
endmodule

// File: rtl/irmod_top.sv
module irmod_top
  import irmod_pkg::*;
#(
  parameter int MW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_clksrc,
  input  logic          cfg_pol,
  input  logic          cfg_latch,
  input  logic [MW-1:0] cfg_mark,
  input  logic [MW-1:0] cfg_space,
  input  logic [CW-1:0] cfg_hi1,
  input  logic [CW-1:0] cfg_lo1,
  input  logic [CW-1:0] cfg_hi2,
  input  logic [CW-1:0] cfg_lo2,
  output logic          ir_out,
  output logic          period_done
);
  mode_t mode;
  logic  en_q, start, active, is_fsk;
  logic  carrier, ctick, mtick;
  logic  gate, sel, fsk_switch;

  assign mode   = mode_t'(cfg_mode);
  assign is_fsk = (mode == MODE_FSK);
  assign start  = cfg_en & ~en_q;
  assign active = cfg_en & en_q;
  // FSK always counts carrier periods
  assign mtick  = (is_fsk | cfg_clksrc) ? ctick : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= cfg_en;
  end

  irmod_carrier #(.CW(CW)) u_carrier (
    .clk        (clk),
    .rst        (rst),
    .run        (active),
    .restart    (start | fsk_switch),
    .sel        (sel),
    .hi1        (cfg_hi1),
    .lo1        (cfg_lo1),
    .hi2        (cfg_hi2),
    .lo2        (cfg_lo2),
    .carrier    (carrier),
    .period_end (ctick)
  );

  irmod_modtimer #(.MW(MW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .run        (active),
    .tick       (mtick),
    .fsk        (is_fsk),
    .mark       (cfg_mark),
    .space      (cfg_space),
    .gate       (gate),
    .done       (period_done),
    .sel        (sel),
    .fsk_switch (fsk_switch)
  );

  irmod_outstage u_out (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .mode    (mode),
    .gate    (gate),
    .carrier (carrier),
    .latch   (cfg_latch),
    .pol     (cfg_pol),
    .ir_out  (ir_out)
  );

  // R11: with the carrier-period tick and no carrier period ending, no reload occurs
  p_slow_tick_r11: assert property (@(posedge clk) disable iff (rst)
    (active && cfg_clksrc && !ctick && !start) |=> !period_done);
endmodule

// File: tb/tb_irmod_top.sv
module tb_irmod_top;
  localparam int MW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 0, cfg_clksrc = 0, cfg_pol = 0, cfg_latch = 0;
  logic [1:0] cfg_mode = 0;
  logic [MW-1:0] cfg_mark = 0, cfg_space = 0;
  logic [CW-1:0] cfg_hi1 = 1, cfg_lo1 = 1, cfg_hi2 = 1, cfg_lo2 = 1;
  logic ir_out, period_done;

  always #4 clk = ~clk;

  irmod_top #(.MW(MW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_clksrc(cfg_clksrc), .cfg_pol(cfg_pol), .cfg_latch(cfg_latch),
    .cfg_mark(cfg_mark), .cfg_space(cfg_space), .cfg_hi1(cfg_hi1),
    .cfg_lo1(cfg_lo1), .cfg_hi2(cfg_hi2), .cfg_lo2(cfg_lo2),
    .ir_out(ir_out), .period_done(period_done)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  logic          m_enq, m_ph, m_sel, m_done, m_ir;
  logic [CW-1:0] m_cc;
  logic [MW:0]   m_cnt;
  logic [MW-1:0] m_ssp;
  string         m_tag;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] eff(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  // advance the reference by one clock edge, using the current inputs
  task automatic model_step();
    logic st, act, fsk, ctick, mt, gate, wrap, modout, fsw;
    logic [CW-1:0] hi, lo;
    if (rst) begin
      m_enq = 0; m_ph = 1; m_cc = 0; m_cnt = 0; m_ssp = 0;
      m_sel = 0; m_done = 0; m_ir = 0; m_tag = "R1";
      return;
    end
    st    = cfg_en & ~m_enq;
    act   = cfg_en & m_enq;
    fsk   = (cfg_mode == 2'd2);
    hi    = eff(m_sel ? cfg_hi2 : cfg_hi1);
    lo    = eff(m_sel ? cfg_lo2 : cfg_lo1);
    ctick = act & ~m_ph & (m_cc == lo - CW'(1));
    mt    = (fsk | cfg_clksrc) ? ctick : 1'b1;
    gate  = ~m_cnt[MW];
    wrap  = m_cnt[MW] & ((~m_cnt[MW-1:0]) == m_ssp);
    if (fsk)                 modout = m_ph;
    else if (cfg_mode == 1)  modout = gate;
    else                     modout = gate & m_ph;
    if (!act)                m_tag = "R6";
    else if (fsk)            m_tag = "R5";
    else if (cfg_mode == 1)  m_tag = "R4";
    else                     m_tag = "R3";
    m_ir = (act ? modout : cfg_latch) ^ cfg_pol;
    fsw  = act & mt & wrap & fsk;
    if (st || fsw) begin
      m_ph = 1; m_cc = 0;
    end else if (act) begin
      if (m_ph) begin
        if (m_cc == hi - CW'(1)) begin m_ph = 0; m_cc = 0; end
        else m_cc = m_cc + CW'(1);
      end else begin
        if (m_cc == lo - CW'(1)) begin m_ph = 1; m_cc = 0; end
        else m_cc = m_cc + CW'(1);
      end
    end
    if (st) begin
      m_cnt = {1'b0, cfg_mark}; m_ssp = cfg_space; m_sel = 0; m_done = 0;
    end else if (act && mt) begin
      if (wrap) begin
        m_cnt = {1'b0, cfg_mark}; m_ssp = cfg_space; m_done = 1;
        if (fsk) m_sel = ~m_sel;
      end else begin
        m_cnt = m_cnt - 1'b1; m_done = 0;
      end
    end else begin
      m_done = 0;
    end
    m_enq = cfg_en;
  endtask

  // one clock: model, edge, sample at the falling edge, compare
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(ir_out === m_ir, m_tag, int'(ir_out), int'(m_ir));
    chk(period_done === m_done, "R2 pulse", int'(period_done), int'(m_done));
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      cyc();
      n++;
    end while (!period_done && n < 2000);
  endtask

  task automatic restart_en();
    cfg_en = 0; cyc(); cyc();
    cfg_en = 1; cyc();
  endtask

  int n, n1, n2, ones;

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(); cyc(); cyc();
    rst = 0;
    cyc();
    chk(ir_out === 1'b0 && period_done === 1'b0, "R1 reset", int'(ir_out), 0);

    // R2: mark 3 space 2 on the per-cycle tick
    cfg_mode = 1; cfg_clksrc = 0; cfg_mark = 3; cfg_space = 2;
    restart_en();
    wait_done(n); wait_done(n);
    chk(n == 7, "R2 period", n, 7);

    // R8: zero mark and space
    cfg_mark = 0; cfg_space = 0;
    wait_done(n); wait_done(n);
    chk(n == 2, "R8 zero period", n, 2);

    // R9: mid-period change waits for the next reload
    cfg_mark = 5; cfg_space = 5;
    wait_done(n); wait_done(n);
    cfg_mark = 0; cfg_space = 0;
    wait_done(n);
    chk(n == 12, "R9 old values kept", n, 12);
    wait_done(n);
    chk(n == 2, "R9 new values used", n, 2);

    // R11: carrier-period tick, carrier period 2, timer period 3 ticks
    cfg_clksrc = 1; cfg_hi1 = 1; cfg_lo1 = 1; cfg_mark = 1; cfg_space = 0;
    restart_en();
    wait_done(n); wait_done(n);
    chk(n == 6, "R11 carrier tick", n, 6);
    cfg_clksrc = 0;

    // R10: duty 3 high, 2 low in time mode
    cfg_mode = 0; cfg_hi1 = 3; cfg_lo1 = 2; cfg_mark = 1000; cfg_space = 0;
    restart_en();
    repeat (10) cyc();
    ones = 0;
    for (int i = 0; i < 25; i++) begin cyc(); ones += int'(ir_out); end
    chk(ones == 15, "R10 duty", ones, 15);
    cfg_hi1 = 0; cfg_lo1 = 0;
    repeat (4) cyc();
    ones = 0;
    for (int i = 0; i < 20; i++) begin cyc(); ones += int'(ir_out); end
    chk(ones == 10, "R10 zero count as one", ones, 10);

    // R12: restart in the high phase, hi 2 lo 2
    cfg_hi1 = 2; cfg_lo1 = 2; cfg_latch = 0;
    cfg_en = 0; cyc(); cyc();
    cfg_en = 1; cyc();
    chk(ir_out === 1'b0, "R12 first edge latch", int'(ir_out), 0);
    cyc(); chk(ir_out === 1'b1, "R12 edge1", int'(ir_out), 1);
    cyc(); chk(ir_out === 1'b1, "R12 edge2", int'(ir_out), 1);
    cyc(); chk(ir_out === 1'b0, "R12 edge3", int'(ir_out), 0);
    cyc(); chk(ir_out === 1'b0, "R12 edge4", int'(ir_out), 0);
    cyc(); chk(ir_out === 1'b1, "R12 edge5", int'(ir_out), 1);

    // R5: FSK with set 1 period 2 and set 2 period 4, two carrier periods each
    cfg_mode = 2; cfg_hi2 = 2; cfg_lo2 = 2; cfg_hi1 = 1; cfg_lo1 = 1;
    cfg_mark = 0; cfg_space = 0;
    restart_en();
    wait_done(n); wait_done(n1); wait_done(n2);
    chk((n1 == 4 && n2 == 8) || (n1 == 8 && n2 == 4), "R5 fsk alternation", n1 * 100 + n2, 408);

    // R6 and R7: latch and polarity
    cfg_en = 0; cfg_latch = 1; cfg_pol = 1; cyc(); cyc();
    chk(ir_out === 1'b0, "R7 inverted latch", int'(ir_out), 0);
    cfg_pol = 0; cyc();
    chk(ir_out === 1'b1, "R6 latch high", int'(ir_out), 1);
    cfg_latch = 0; cyc();
    chk(ir_out === 1'b0, "R6 latch low", int'(ir_out), 0);
    cfg_mode = 1; cfg_mark = 1000; cfg_pol = 1;
    restart_en(); cyc();
    chk(ir_out === 1'b0, "R7 inverted open gate", int'(ir_out), 0);
    cfg_pol = 0;

    // random mix
    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(0, 299) == 0) cfg_en = ~cfg_en;
      if ($urandom_range(0, 39) == 0) begin
        case ($urandom_range(0, 9))
          0: cfg_mode   = 2'($urandom_range(0, 3));
          1: cfg_clksrc = 1'($urandom_range(0, 1));
          2: cfg_pol    = 1'($urandom_range(0, 1));
          3: cfg_latch  = 1'($urandom_range(0, 1));
          4: cfg_mark   = MW'($urandom_range(0, 7));
          5: cfg_space  = MW'($urandom_range(0, 7));
          6: cfg_hi1    = CW'($urandom_range(0, 4));
          7: cfg_lo1    = CW'($urandom_range(0, 4));
          8: cfg_hi2    = CW'($urandom_range(0, 4));
          default: cfg_lo2 = CW'($urandom_range(0, 4));
        endcase
      end
      cyc();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule